// File: doc/BRIEF.md
# Floating-point status and control register

This block holds the 32-bit status and control word of a floating-point coprocessor. Software writes the word through a single write port, and a fixed writable mask removes every bit that has no function. The 3-bit rounding field drives a small state machine. The machine holds the active rounding mode and presents it to the arithmetic datapath as a 4-bit one-hot control. Codes the datapath cannot honour do not change the mode and raise an error pulse instead.

Two further sources feed the register. The datapath reports five IEEE exception conditions as single-cycle pulses, and the block collects them in sticky flag cells. A software write reloads those cells from the trap-enable field of the written word. Reads are combinational: the stored control bits ORed with the live flag cells. An external compare unit can load the comparison-result bit at any time.

The rounding state machine has four states, one for each supported mode: RM_NEAREST (code 0, round to nearest even), RM_ZERO (code 1, toward zero), RM_UP (code 2, toward plus infinity) and RM_DOWN (code 3, toward minus infinity). A transition happens only on a write whose rounding field differs from the stored one and carries a code from 0 to 3. That write moves the machine to the state named by the code, and the move may be to the current state. Any other cycle keeps the state, including a write that leaves the field unchanged and a write that changes it to a code from 4 to 7. Reset enters RM_NEAREST.

Top module: `fpsr_unit`

## Requirements
- R1: After reset `rd_data` is 0, `rnd_onehot` is 4'b0001 (nearest even), `rnd_err` is 0 and `cmp_flag` is 0.
- R2: Only bits [12:0] and bit 29 of a written word are kept. Every other bit of `rd_data` always reads 0.
- R3: A write that changes the rounding field (bits [2:0]) to code 0, 1, 2 or 3 sets `rnd_onehot` after the write edge to 4'b0001, 4'b0010, 4'b0100 or 4'b1000 respectively (nearest even, toward zero, toward plus infinity, toward minus infinity).
- R4: A write that changes the rounding field to a code from 4 to 7 raises `rnd_err` for exactly the cycle after the write edge. `rnd_onehot` keeps its previous value, and `rd_data[2:0]` shows the written code.
- R5: The rounding control and the error output react only to a write that changes the rounding field. Rewriting the stored code raises no error, even when that code is unsupported.
- R6: A pulse on `dp_flags` (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact) sets the matching bit of `rd_data[7:3]` (bit 3 invalid to bit 7 inexact). The bit stays set on later cycles without a write.
- R7: After a write, `rd_data` equals the masked written word ORed with its trap-enable field (bits [12:8], same flag order) copied into bits [7:3].
- R8: When a write and a `dp_flags` pulse fall in the same cycle, the flag bits after the edge hold both the reloaded trap-enable bits and the pulsed bits.
- R9: `cmp_upd` loads `cmp_val` into bit 29 (`cmp_flag`), and it takes priority over a software write in the same cycle. A write alone sets bit 29 from the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write word |
| rd_data | output | 32 | Stored control bits merged with live flags |
| dp_flags | input | 5 | Exception pulses from the datapath |
| cmp_upd | input | 1 | Compare unit update strobe |
| cmp_val | input | 1 | Compare result to store |
| cmp_flag | output | 1 | Stored compare-result bit |
| rnd_onehot | output | 4 | One-hot rounding control to the datapath |
| rnd_err | output | 1 | Unsupported rounding-code pulse |

## Verification
The bench rewrites an unsupported code that is already stored and then moves from an unsupported code back to a supported one. A design without change detection would raise a second error on the rewrite. A design that adopted bad codes would show a corrupt or all-zero one-hot control. Sticky pulses are accumulated over several cycles and then cleared by a write whose trap field reloads only some of them, which exposes a design that clears everything or keeps stale flags. Same-cycle collisions pit a write against a flag pulse and a write against a compare update. A wrong priority there drops the pulse or loses the compare result.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    parameter int unsigned XLEN     = 32;
    parameter int unsigned RND_LSB  = 0;
    parameter int unsigned RND_W    = 3;
    parameter int unsigned FLAG_LSB = 3;
    parameter int unsigned NFLAG    = 5;
    parameter int unsigned TRAP_LSB = 8;
    parameter int unsigned CMP_BIT  = 29;
    parameter int unsigned NMODE    = 4;

    function automatic logic [XLEN-1:0] write_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < RND_W; i++)  m[RND_LSB + i]  = 1'b1;
        for (int i = 0; i < NFLAG; i++)  m[FLAG_LSB + i] = 1'b1;
        for (int i = 0; i < NFLAG; i++)  m[TRAP_LSB + i] = 1'b1;
        m[CMP_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] WMASK = write_mask();

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rm_state_e;

endpackage

// File: rtl/fpsr_ctrl_store.sv
module fpsr_ctrl_store
    import fpsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            cmp_upd,
    input  logic            cmp_val,
    output logic [XLEN-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en) begin
                ctrl_q <= wr_data & WMASK;
            end
            if (cmp_upd) begin
                ctrl_q[CMP_BIT] <= cmp_val;
            end
        end
    end

endmodule

// File: rtl/fpsr_flag_acc.sv
module fpsr_flag_acc
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_en,
    input  logic [NFLAG-1:0] reload_val,
    input  logic [NFLAG-1:0] pulse,
    output logic [NFLAG-1:0] flags_q
);

    for (genvar g = 0; g < NFLAG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[g] <= 1'b0;
            end else if (reload_en) begin
                flags_q[g] <= reload_val[g] | pulse[g];
            end else begin
                flags_q[g] <= flags_q[g] | pulse[g];
            end
        end
    end

endmodule

// File: rtl/fpsr_round_fsm.sv
module fpsr_round_fsm
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RND_W-1:0] new_code,
    input  logic [RND_W-1:0] old_code,
    output logic [NMODE-1:0] rm_onehot,
    output logic             rm_err
);

    rm_state_e state_q, state_d;
    logic      fld_change;
    logic      bad_code;
    logic      err_d;

    assign fld_change = wr_en && (new_code != old_code);
    assign bad_code   = |new_code[RND_W-1:2];

    always_comb begin
        state_d = state_q;
        err_d   = 1'b0;
        if (fld_change) begin
            if (bad_code) begin
                err_d = 1'b1;
            end else begin
                unique case (new_code[1:0])
                    2'd0: state_d = RM_NEAREST;
                    2'd1: state_d = RM_ZERO;
                    2'd2: state_d = RM_UP;
                    2'd3: state_d = RM_DOWN;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RM_NEAREST;
            rm_err  <= 1'b0;
        end else begin
            state_q <= state_d;
            rm_err  <= err_d;
        end
    end

    always_comb begin
        rm_onehot = '0;
        unique case (state_q)
            RM_NEAREST: rm_onehot[0] = 1'b1;
            RM_ZERO:    rm_onehot[1] = 1'b1;
            RM_UP:      rm_onehot[2] = 1'b1;
            RM_DOWN:    rm_onehot[3] = 1'b1;
        endcase
    end

endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  rd_data,
    input  logic [NFLAG-1:0] dp_flags,
    input  logic             cmp_upd,
    input  logic             cmp_val,
    output logic             cmp_flag,
    output logic [NMODE-1:0] rnd_onehot,
    output logic             rnd_err
);

    localparam int unsigned HI_PAD = XLEN - FLAG_LSB - NFLAG;

    logic [XLEN-1:0]  ctrl_q;
    logic [NFLAG-1:0] flags_q;

    fpsr_ctrl_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmp_upd (cmp_upd),
        .cmp_val (cmp_val),
        .ctrl_q  (ctrl_q)
    );

    fpsr_flag_acc u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_en  (wr_en),
        .reload_val (wr_data[TRAP_LSB +: NFLAG]),
        .pulse      (dp_flags),
        .flags_q    (flags_q)
    );

    fpsr_round_fsm u_round (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .new_code  (wr_data[RND_LSB +: RND_W]),
        .old_code  (ctrl_q[RND_LSB +: RND_W]),
        .rm_onehot (rnd_onehot),
        .rm_err    (rnd_err)
    );

    assign rd_data  = ctrl_q | {{HI_PAD{1'b0}}, flags_q, {FLAG_LSB{1'b0}}};
    assign cmp_flag = ctrl_q[CMP_BIT];

endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk
    import fpsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [XLEN-1:0]  rd_data,
    input logic [NFLAG-1:0] dp_flags,
    input logic             cmp_upd,
    input logic             cmp_val,
    input logic             cmp_flag,
    input logic [NMODE-1:0] rnd_onehot,
    input logic             rnd_err
);

    AST_ONEHOT_CTRL: assert property (@(posedge clk) disable iff (!rst_n) $countones(rnd_onehot) == 1); // R3
    AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_data & ~WMASK) == '0); // R2
    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) rnd_err |-> $past(wr_en)); // R4
    AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n) rnd_err |-> $stable(rnd_onehot)); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(rnd_onehot)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[7:3] & $past(rd_data[7:3])) == $past(rd_data[7:3]))); // R6
    AST_PULSE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_flags != '0) |=> ((rd_data[7:3] & $past(dp_flags)) == $past(dp_flags))); // R8
    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cmp_upd |=> cmp_flag == $past(cmp_val)); // R9

endmodule

bind fpsr_unit fpsr_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .dp_flags   (dp_flags),
    .cmp_upd    (cmp_upd),
    .cmp_val    (cmp_val),
    .cmp_flag   (cmp_flag),
    .rnd_onehot (rnd_onehot),
    .rnd_err    (rnd_err)
);

// File: tb/test_fpsr_unit.sv
module test_fpsr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  dp_flags = '0;
    logic        cmp_upd = 1'b0;
    logic        cmp_val = 1'b0;
    logic        cmp_flag;
    logic [3:0]  rnd_onehot;
    logic        rnd_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpsr_unit i_fpsr_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .dp_flags   (dp_flags),
        .cmp_upd    (cmp_upd),
        .cmp_val    (cmp_val),
        .cmp_flag   (cmp_flag),
        .rnd_onehot (rnd_onehot),
        .rnd_err    (rnd_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock with the given stimulus; returns at the following falling edge
    task automatic cyc(input logic we, input logic [31:0] wd, input logic [4:0] fl,
                       input logic cu, input logic cv);
        @(negedge clk);
        wr_en = we; wr_data = wd; dp_flags = fl; cmp_upd = cu; cmp_val = cv;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; dp_flags = '0; cmp_upd = 1'b0; cmp_val = 1'b0;
    endtask

    task automatic wr(input logic [31:0] wd);
        cyc(1'b1, wd, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 onehot", {28'd0, rnd_onehot}, 32'h1);
        chk("R1 err", {31'd0, rnd_err}, 32'h0);
        chk("R1 cmp", {31'd0, cmp_flag}, 32'h0);
    endtask

    task automatic t_mask;
        wr(32'hDEAD_E0F8);
        chk("R2 mask", rd_data, 32'h0000_00F8);
        chk("R2 onehot", {28'd0, rnd_onehot}, 32'h1);
        wr(32'hFFFF_FFF8);
        chk("R7 mask+reload", rd_data, 32'h2000_1FF8);
    endtask

    task automatic t_round;
        wr(32'h1); chk("R3 zero", {28'd0, rnd_onehot}, 32'h2);
        chk("R3 err", {31'd0, rnd_err}, 32'h0);
        wr(32'h2); chk("R3 up", {28'd0, rnd_onehot}, 32'h4);
        wr(32'h3); chk("R3 down", {28'd0, rnd_onehot}, 32'h8);
        wr(32'h0); chk("R3 nearest", {28'd0, rnd_onehot}, 32'h1);
        chk("R3 read", rd_data, 32'h0);
    endtask

    task automatic t_unsupported;
        wr(32'h2);
        wr(32'h4);
        chk("R4 err pulse", {31'd0, rnd_err}, 32'h1);
        chk("R4 mode kept", {28'd0, rnd_onehot}, 32'h4);
        chk("R4 code read", rd_data, 32'h4);
        @(negedge clk);
        chk("R4 err drops", {31'd0, rnd_err}, 32'h0);
        wr(32'h7);
        chk("R4 code7 err", {31'd0, rnd_err}, 32'h1);
        wr(32'h7);
        chk("R5 rewrite no err", {31'd0, rnd_err}, 32'h0);
        wr(32'h1);
        chk("R5 recover", {28'd0, rnd_onehot}, 32'h2);
        chk("R5 recover err", {31'd0, rnd_err}, 32'h0);
        wr(32'h1);
        chk("R5 same field", {28'd0, rnd_onehot}, 32'h2);
        wr(32'h0);
    endtask

    task automatic t_sticky;
        cyc(1'b0, 32'h0, 5'b00101, 1'b0, 1'b0);
        chk("R6 first pulse", rd_data, 32'h0000_0028);
        cyc(1'b0, 32'h0, 5'b10000, 1'b0, 1'b0);
        chk("R6 accumulate", rd_data, 32'h0000_00A8);
        repeat (3) @(negedge clk);
        chk("R6 held", rd_data, 32'h0000_00A8);
        wr(32'h0000_0300);
        chk("R7 reload", rd_data, 32'h0000_0318);
    endtask

    task automatic t_collide;
        cyc(1'b1, 32'h0000_1000, 5'b00001, 1'b0, 1'b0);
        chk("R8 write+pulse", rd_data, 32'h0000_1088);
        wr(32'h0);
        chk("R7 clear", rd_data, 32'h0);
    endtask

    task automatic t_cmp;
        cyc(1'b0, 32'h0, 5'd0, 1'b1, 1'b1);
        chk("R9 set", {31'd0, cmp_flag}, 32'h1);
        chk("R9 read", rd_data, 32'h2000_0000);
        cyc(1'b1, 32'h2000_0000, 5'd0, 1'b1, 1'b0);
        chk("R9 priority", {31'd0, cmp_flag}, 32'h0);
        wr(32'h2000_0000);
        chk("R9 sw write", {31'd0, cmp_flag}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        wr(32'h0);
        t_round();
        t_unsupported();
        t_sticky();
        t_collide();
        t_cmp();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule